// File: doc/BRIEF.md
# Self-Test Failure Capture Log

This block records failing accesses reported by a memory self-test engine. Each clock cycle the engine may raise a single-cycle mismatch pulse. The pulse comes with the address that failed and the corrupted data read back from it. A free-running failure counter tallies every pulse. A programmable skip pointer decides which failures are kept: the first N failures after a clear pass by without being stored, and the failures that follow fill a small bank of address/data capture slots.

Software loads the skip pointer and clears the log before a test pass. After the pass it reads the slots, the number of slots filled, a full flag and the total failure count. A non-zero pointer lets a second pass capture failures that occur deep in a test, which would otherwise be hidden behind the earliest ones. Any per-bit failure accumulation runs elsewhere, sees every failure and is not gated by the pointer.

Top module: `bist_fail_log`

## Requirements
- R1: After reset all slot valid bits are 0, the slot count is 0, the full flag is 0, the failure counter is 0 and the pointer is 0.
- R2: A cycle with ptr_wr_i high loads ptr_wdata_i into the pointer, and ptr_o shows it in the next cycle.
- R3: Each cycle with fail_i high and clr_i low adds one to fail_cnt_o in the next cycle. At the all-ones value the counter holds. Without a pulse it holds.
- R4: A failure is stored only when the failure count before that failure is greater than or equal to the pointer. A pointer of 0 stores from the first failure, and a pointer of N stores from failure N+1 onward.
- R5: Stored failures fill the slots in ascending index order. Slot k holds the address and data of the (k+1)-th stored failure. Slot k occupies bits [k*ADDR_W +: ADDR_W] of slot_addr_o, bits [k*DATA_W +: DATA_W] of slot_data_o and bit k of slot_vld_o. The slot contents and the valid bit appear one cycle after the pulse.
- R6: fill_cnt_o equals the number of valid slots. full_o is 1 exactly when all SLOTS slots are valid.
- R7: Once the log is full, further failures still advance fail_cnt_o, but the slot addresses, data and valid bits stay unchanged.
- R8: A cycle with clr_i high empties all slots and sets the failure counter and the slot count to 0 in the next cycle. The pointer keeps its value. A fail pulse in the same cycle as a clear is neither counted nor stored.
- R9: When a pointer write and a fail pulse fall in the same cycle, the failure is judged against the pointer value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear slots and failure counter |
| ptr_wr_i | input | 1 | Pointer write strobe |
| ptr_wdata_i | input | CNT_W (32) | New pointer value |
| fail_i | input | 1 | Compare-fail pulse |
| fail_addr_i | input | ADDR_W (32) | Failing address |
| fail_data_i | input | DATA_W (64) | Corrupted read data |
| slot_vld_o | output | SLOTS (4) | Per-slot valid bits |
| slot_addr_o | output | SLOTS*ADDR_W | Slot addresses, slot 0 in the low bits |
| slot_data_o | output | SLOTS*DATA_W | Slot data, slot 0 in the low bits |
| fill_cnt_o | output | $clog2(SLOTS+1) | Number of filled slots |
| full_o | output | 1 | All slots filled |
| fail_cnt_o | output | CNT_W (32) | Total failures since clear |
| ptr_o | output | CNT_W (32) | Current skip pointer |

## Verification
Every result is due one clock edge after the stimulus that causes it: slot contents, valid bits, slot count, full flag, failure count and pointer all come from a single register stage. The bench drives inputs on the falling edge and samples on the next falling edge, which lies after exactly one rising edge. The slot count is therefore checked after every single pulse, and the slot contents and the counter at the end of each sweep run. A second instance with a 4-bit counter reaches saturation within a few pulses.

// File: rtl/bist_log_pkg.sv
package bist_log_pkg;

  localparam int unsigned SLOTS_DEF = 4;

  // Decision for one cycle's fail pulse
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_SKIP  = 2'd1,
    EV_STORE = 2'd2,
    EV_DROP  = 2'd3
  } fail_ev_e;

endpackage

// File: rtl/bist_fail_ptr.sv
module bist_fail_ptr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] ptr_o
);

  logic [CNT_W-1:0] ptr_q;

  // only the async reset touches it; clear leaves it alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_q <= '0;
    else if (wr_i) ptr_q <= wdata_i;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/bist_fail_count.sv
module bist_fail_count
  import bist_log_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             fail_i,
  input  logic [CNT_W-1:0] ptr_i,
  input  logic             full_i,
  output logic [CNT_W-1:0] cnt_o,
  output fail_ev_e         ev_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                 cnt_d = '0;
    else if (fail_i && !at_max) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // judged on the pre-increment count and the currently held pointer
  always_comb begin
    if (!fail_i || clr_i)  ev_o = EV_NONE;
    else if (cnt_q < ptr_i) ev_o = EV_SKIP;
    else if (full_i)        ev_o = EV_DROP;
    else                    ev_o = EV_STORE;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/bist_fail_slots.sv
module bist_fail_slots
  import bist_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned FILL_W = $clog2(SLOTS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  fail_ev_e               ev_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [SLOTS-1:0]       vld_o,
  output logic [SLOTS*ADDR_W-1:0] addr_o,
  output logic [SLOTS*DATA_W-1:0] data_o,
  output logic [FILL_W-1:0]      fill_o,
  output logic                   full_o
);

  logic [FILL_W-1:0]             fill_q;
  logic                          store;
  logic [SLOTS-1:0]              vld_q;
  logic [SLOTS-1:0][ADDR_W-1:0]  addr_q;
  logic [SLOTS-1:0][DATA_W-1:0]  data_q;

  assign store  = (ev_i == EV_STORE);
  assign full_o = (fill_q == FILL_W'(SLOTS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fill_q <= '0;
    else if (clr_i) fill_q <= '0;
    else if (store) fill_q <= fill_q + 1'b1;
  end

  // fill pointer selects the target slot directly, no priority encoder
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic hit;
    assign hit = store && (fill_q == FILL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_q[k] <= 1'b0;
      else if (clr_i) vld_q[k] <= 1'b0;
      else if (hit)   vld_q[k] <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[k] <= '0;
        data_q[k] <= '0;
      end else if (hit) begin
        addr_q[k] <= addr_i;
        data_q[k] <= data_i;
      end
    end
  end

  assign vld_o  = vld_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign fill_o = fill_q;

endmodule

// File: rtl/bist_fail_log.sv
module bist_fail_log
  import bist_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SLOTS  = SLOTS_DEF,
  localparam int unsigned FILL_W = $clog2(SLOTS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    ptr_wr_i,
  input  logic [CNT_W-1:0]        ptr_wdata_i,
  input  logic                    fail_i,
  input  logic [ADDR_W-1:0]       fail_addr_i,
  input  logic [DATA_W-1:0]       fail_data_i,
  output logic [SLOTS-1:0]        slot_vld_o,
  output logic [SLOTS*ADDR_W-1:0] slot_addr_o,
  output logic [SLOTS*DATA_W-1:0] slot_data_o,
  output logic [FILL_W-1:0]       fill_cnt_o,
  output logic                    full_o,
  output logic [CNT_W-1:0]        fail_cnt_o,
  output logic [CNT_W-1:0]        ptr_o
);

  logic [CNT_W-1:0] ptr;
  logic             full;
  fail_ev_e         ev;

  bist_fail_ptr #(.CNT_W(CNT_W)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ptr_wr_i),
    .wdata_i (ptr_wdata_i),
    .ptr_o   (ptr)
  );

  bist_fail_count #(.CNT_W(CNT_W)) i_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .fail_i (fail_i),
    .ptr_i  (ptr),
    .full_i (full),
    .cnt_o  (fail_cnt_o),
    .ev_o   (ev)
  );

  bist_fail_slots #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SLOTS  (SLOTS)
  ) i_slots (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .ev_i   (ev),
    .addr_i (fail_addr_i),
    .data_i (fail_data_i),
    .vld_o  (slot_vld_o),
    .addr_o (slot_addr_o),
    .data_o (slot_data_o),
    .fill_o (fill_cnt_o),
    .full_o (full)
  );

  assign full_o = full;
  assign ptr_o  = ptr;

endmodule

// File: rtl/bist_fail_log_chk.sv
module bist_fail_log_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned FILL_W = $clog2(SLOTS + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    clr_i,
  input logic                    ptr_wr_i,
  input logic [CNT_W-1:0]        ptr_wdata_i,
  input logic                    fail_i,
  input logic [SLOTS-1:0]        slot_vld_o,
  input logic [SLOTS*ADDR_W-1:0] slot_addr_o,
  input logic [SLOTS*DATA_W-1:0] slot_data_o,
  input logic [FILL_W-1:0]       fill_cnt_o,
  input logic                    full_o,
  input logic [CNT_W-1:0]        fail_cnt_o,
  input logic [CNT_W-1:0]        ptr_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr_i |=> ptr_o == $past(ptr_wdata_i));

  a_r3_cnt_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !clr_i && fail_cnt_o != CNT_MAX) |=> fail_cnt_o == $past(fail_cnt_o) + 1'b1);

  a_r3_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !clr_i && fail_cnt_o == CNT_MAX) |=> fail_cnt_o == CNT_MAX);

  a_r4_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !clr_i && fail_cnt_o < ptr_o) |=> $stable(slot_vld_o));

  a_r4_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !clr_i && !full_o && fail_cnt_o >= ptr_o)
      |=> $countones(slot_vld_o) == $countones($past(slot_vld_o)) + 1);

  a_r6_fill_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_vld_o) == int'(fill_cnt_o));

  a_r6_full_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (&slot_vld_o));

  a_r7_hold_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clr_i) |=> $stable(slot_addr_o) && $stable(slot_data_o) && $stable(slot_vld_o));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (fail_cnt_o == '0) && (slot_vld_o == '0) && (fill_cnt_o == '0));

  a_r8_ptr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ptr_wr_i) |=> $stable(ptr_o));

endmodule

bind bist_fail_log bist_fail_log_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .SLOTS  (SLOTS)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .ptr_wr_i    (ptr_wr_i),
  .ptr_wdata_i (ptr_wdata_i),
  .fail_i      (fail_i),
  .slot_vld_o  (slot_vld_o),
  .slot_addr_o (slot_addr_o),
  .slot_data_o (slot_data_o),
  .fill_cnt_o  (fill_cnt_o),
  .full_o      (full_o),
  .fail_cnt_o  (fail_cnt_o),
  .ptr_o       (ptr_o)
);

// File: tb/test_bist_fail_log.sv
module test_bist_fail_log;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 32;
  localparam int SCW = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // main instance
  logic           clr, pwr, fail;
  logic [CW-1:0]  pwd;
  logic [AW-1:0]  faddr;
  logic [DW-1:0]  fdata;
  logic [NS-1:0]  vld;
  logic [NS*AW-1:0] saddr;
  logic [NS*DW-1:0] sdata;
  logic [2:0]     fill;
  logic           full;
  logic [CW-1:0]  fcnt, ptr;

  bist_fail_log #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .SLOTS(NS)) i_bist_fail_log (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .ptr_wr_i(pwr), .ptr_wdata_i(pwd),
    .fail_i(fail), .fail_addr_i(faddr), .fail_data_i(fdata),
    .slot_vld_o(vld), .slot_addr_o(saddr), .slot_data_o(sdata),
    .fill_cnt_o(fill), .full_o(full), .fail_cnt_o(fcnt), .ptr_o(ptr)
  );

  // narrow counter instance for saturation
  logic           s_clr, s_pwr, s_fail;
  logic [SCW-1:0] s_pwd;
  logic [AW-1:0]  s_faddr;
  logic [DW-1:0]  s_fdata;
  logic [NS-1:0]  s_vld;
  logic [NS*AW-1:0] s_saddr;
  logic [NS*DW-1:0] s_sdata;
  logic [2:0]     s_fill;
  logic           s_full;
  logic [SCW-1:0] s_fcnt, s_ptr;

  bist_fail_log #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(SCW), .SLOTS(NS)) i_bist_fail_log_sat (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(s_clr), .ptr_wr_i(s_pwr), .ptr_wdata_i(s_pwd),
    .fail_i(s_fail), .fail_addr_i(s_faddr), .fail_data_i(s_fdata),
    .slot_vld_o(s_vld), .slot_addr_o(s_saddr), .slot_data_o(s_sdata),
    .fill_cnt_o(s_fill), .full_o(s_full), .fail_cnt_o(s_fcnt), .ptr_o(s_ptr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int run, input int i);
    return AW'(run * 37 + i * 5 + 1);
  endfunction

  function automatic logic [DW-1:0] mk_data(input int run, input int i);
    return ~DW'(run * 11 + i * 3);
  endfunction

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic do_ptr(input logic [CW-1:0] v);
    @(negedge clk); pwr = 1'b1; pwd = v;
    @(negedge clk); pwr = 1'b0;
  endtask

  // one pulse; returns at the negedge right after the capturing posedge
  task automatic do_fail(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); fail = 1'b1; faddr = a; fdata = d;
    @(negedge clk); fail = 1'b0;
  endtask

  task automatic s_do_fail(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); s_fail = 1'b1; s_faddr = a; s_fdata = d;
    @(negedge clk); s_fail = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int run;
    clr = 0; pwr = 0; pwd = '0; fail = 0; faddr = '0; fdata = '0;
    s_clr = 0; s_pwr = 0; s_pwd = '0; s_fail = 0; s_faddr = '0; s_fdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 vld", 64'(vld), 0);
    chk("R1 fill", 64'(fill), 0);
    chk("R1 full", 64'(full), 0);
    chk("R1 fail_cnt", 64'(fcnt), 0);
    chk("R1 ptr", 64'(ptr), 0);

    // R9: pointer write coincides with first fail, old pointer 0 applies
    @(negedge clk); pwr = 1'b1; pwd = 5; fail = 1'b1; faddr = 16'hbeef; fdata = 16'h1234;
    @(negedge clk); pwr = 1'b0; fail = 1'b0;
    chk("R9 stored with old ptr", 64'(vld), 1);
    chk("R9 slot0 addr", 64'(saddr[AW-1:0]), 64'h beef);
    chk("R2 ptr loaded", 64'(ptr), 5);

    // R8: clear with simultaneous fail
    @(negedge clk); clr = 1'b1; fail = 1'b1;
    @(negedge clk); clr = 1'b0; fail = 1'b0;
    chk("R8 cnt zero", 64'(fcnt), 0);
    chk("R8 vld zero", 64'(vld), 0);
    chk("R8 fill zero", 64'(fill), 0);
    chk("R8 ptr kept", 64'(ptr), 5);

    // sweep: pointer 0..7, failure count 0..12
    run = 0;
    for (int p = 0; p < 8; p++) begin
      for (int nf = 0; nf <= 12; nf++) begin
        do_ptr(CW'(p));
        chk("R2 ptr", 64'(ptr), 64'(p));
        do_clear();
        chk("R8 cleared cnt", 64'(fcnt), 0);
        chk("R8 ptr unchanged", 64'(ptr), 64'(p));
        for (int i = 0; i < nf; i++) begin
          int exp_fill;
          if (i % 3 == 2) @(negedge clk);
          do_fail(mk_addr(run, i), mk_data(run, i));
          exp_fill = (i + 1 - p) < 0 ? 0 : ((i + 1 - p) > NS ? NS : (i + 1 - p));
          chk("R4 R5 fill after pulse", 64'(fill), 64'(exp_fill));
        end
        chk("R3 fail_cnt", 64'(fcnt), 64'(nf));
        begin
          int nst;
          nst = (nf - p) < 0 ? 0 : ((nf - p) > NS ? NS : (nf - p));
          chk("R6 fill", 64'(fill), 64'(nst));
          chk("R6 full", 64'(full), 64'(nst == NS));
          for (int k = 0; k < NS; k++) begin
            chk("R5 vld", 64'(vld[k]), 64'(k < nst));
            if (k < nst) begin
              // R4: slot k holds failure index p+k; R7 later ones never land
              chk("R5 addr", 64'(saddr[k*AW +: AW]), 64'(mk_addr(run, p + k)));
              chk("R5 data", 64'(sdata[k*DW +: DW]), 64'(mk_data(run, p + k)));
            end
          end
        end
        run++;
      end
    end

    // R7: full log, more failures counted but slots untouched
    do_ptr('0);
    do_clear();
    for (int i = 0; i < 6; i++) do_fail(mk_addr(999, i), mk_data(999, i));
    chk("R7 cnt advances", 64'(fcnt), 6);
    chk("R7 slot3 addr", 64'(saddr[3*AW +: AW]), 64'(mk_addr(999, 3)));
    chk("R7 slot0 data", 64'(sdata[0 +: DW]), 64'(mk_data(999, 0)));
    chk("R7 vld", 64'(vld), 64'hf);

    // R3 saturation on narrow counter, pointer 13
    @(negedge clk); s_pwr = 1'b1; s_pwd = 4'd13;
    @(negedge clk); s_pwr = 1'b0;
    for (int i = 0; i < 20; i++) s_do_fail(mk_addr(500, i), mk_data(500, i));
    chk("R3 saturated", 64'(s_fcnt), 15);
    chk("R6 sat full", 64'(s_full), 1);
    for (int k = 0; k < NS; k++)
      chk("R4 sat slot addr", 64'(s_saddr[k*AW +: AW]), 64'(mk_addr(500, 13 + k)));
    s_do_fail(16'h0, 16'h0);
    chk("R3 sat hold", 64'(s_fcnt), 15);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule